// File: doc/BRIEF.md
# Center-Aligned PWM Channel Pair

The block drives two PWM outputs, one for an even channel and one for an odd channel, from up-down counters. While a channel is enabled, its counter climbs from zero to a programmed turning value and then falls back to zero. One such up-and-down sweep forms one PWM period. The counter flags the bottom of the sweep with a zero-point pulse and the top with a center-point pulse. Each channel has its own compare value. The compare logic raises one pulse when the count meets that value on the way up and another when it meets it on the way down. The PWM output goes high on the first pulse and low on the second, which gives a pulse centred on the top of the sweep.

A single mode input selects how the two channels are paired. In independent mode, each channel compares against its own counter, which uses its own period. In complementary mode, both compare values are checked against the even channel's counter and the odd counter plays no part in the compare logic. In that mode the odd output is the logical inverse of the even output. New period and compare values take effect only at the zero point, so a running period is always completed as it was started.

Top module: `pwm_pair_center`

## Requirements
- R1: While enabled with period P ≥ 1, a counter steps by exactly one on each clock: 0,1,…,P,P-1,…,1,0,1,… so one period is 2·P clocks. With P = 0 it holds at 0.
- R2: The direction flag `dir_up_o` is 1 while counting up and 0 while counting down. It reads 0 in the cycle the count shows P and 1 in every cycle the count shows 0, so 0 and P are each held for one clock.
- R3: While `en_i[n]` is 0, counter n is held at 0 with the direction flag at 1, and its zero and center pulses stay 0. In independent mode its PWM output is 0. On the first enabled clock edge the count becomes 1.
- R4: `zero_evt_o[n]` is high for one cycle, the cycle in which the count has come down to 0. `center_evt_o[n]` is high for one cycle, the cycle in which the count shows P. Each fires once per period.
- R5: `cmpu_evt_o[n]` is high for one cycle when the count reaches compare value C while rising, for C in 1..P. `cmpd_evt_o[n]` is high for one cycle when the count reaches C while falling, for C in 0..P-1. The two are never high together, and values outside those ranges produce no pulse.
- R6: A PWM output is set in the cycle of its up-compare pulse and cleared in the cycle of its down-compare pulse. For 1 ≤ C ≤ P-1 it is therefore high for 2·(P−C) clocks per period. With C = P it goes high once and stays high.
- R7: With `comp_mode_i` = 0 (independent), channel 1 uses its own counter and its own period for compare pulses and output.
- R8: With `comp_mode_i` = 1 (complementary), both compare values are matched against the channel 0 counter, and channel 1's counter and period have no effect on any compare pulse. `pwm_o[1]` is the inverse of `pwm_o[0]`. Counter 1 keeps producing its own zero and center pulses.
- R9: The period and compare inputs are captured when the count is at 0 and take effect from that zero point. A change made mid-period does not alter the current period.
- R10: After reset all counts are 0, all direction flags are 1, and all pulses and PWM outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 2 | Counter enable per channel |
| comp_mode_i | input | 1 | 0 independent, 1 complementary |
| period_i | input | 2×CNT_W | Turning value per channel |
| cmp_i | input | 2×CNT_W | Compare value per channel |
| cnt_o | output | 2×CNT_W | Counter value per channel |
| dir_up_o | output | 2 | 1 while counting up |
| zero_evt_o | output | 2 | Zero-point pulse |
| center_evt_o | output | 2 | Center-point pulse |
| cmpu_evt_o | output | 2 | Compare pulse on rising count |
| cmpd_evt_o | output | 2 | Compare pulse on falling count |
| pwm_o | output | 2 | PWM levels |

## Verification
Every output of the block is a register. Each output is updated on the same clock edge at which the count takes its new value, so a pulse lines up with the cycle in which `cnt_o` shows the matching value. An input applied before an edge shows up on the outputs right after that edge. The bench drives inputs on the falling edge and samples on the next falling edge, so each sample reflects exactly one rising edge. Sweep tests count pulses and PWM-high cycles over a window of exactly 2·P0·P1 clocks, which is a whole number of periods for both channels. This makes the expected totals depend only on P and C.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int NUM_CH = 2;
  localparam int EVEN_CH = 0;

  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_COMPL = 1'b1
  } pair_mode_e;
endpackage

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             step_up_o,
  output logic             step_dn_o,
  output logic             at_zero_o,
  output logic             zero_evt_o,
  output logic             center_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_eff;
  logic             dir_q, dir_d, zero_q, center_q;
  logic             up, dn;

  assign at_zero_o = (cnt_q == '0);
  // new period applies straight from the zero point
  assign per_eff   = at_zero_o ? period_i : per_q;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    up    = 1'b0;
    dn    = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
      dir_d = 1'b1;
    end else if (per_eff != '0) begin
      if (dir_q) begin
        up    = 1'b1;
        cnt_d = cnt_q + 1'b1;
      end else begin
        dn    = 1'b1;
        cnt_d = cnt_q - 1'b1;
      end
      if (cnt_d == per_eff)  dir_d = 1'b0;
      else if (cnt_d == '0)  dir_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_q    <= 1'b1;
      per_q    <= '0;
      zero_q   <= 1'b0;
      center_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      dir_q    <= dir_d;
      if (at_zero_o) per_q <= period_i;
      zero_q   <= dn && (cnt_d == '0);
      center_q <= up && (cnt_d == per_eff);
    end
  end

  assign cnt_o        = cnt_q;
  assign dir_up_o     = dir_q;
  assign cnt_nxt_o    = cnt_d;
  assign step_up_o    = up;
  assign step_dn_o    = dn;
  assign zero_evt_o   = zero_q;
  assign center_evt_o = center_q;
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             at_zero_i,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             cmpu_evt_o,
  output logic             cmpd_evt_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_q, cmp_eff;
  logic             hit, cu_d, cd_d, pwm_d;
  logic             cu_q, cd_q, pwm_q;

  assign cmp_eff = at_zero_i ? cmp_i : cmp_q;
  assign hit     = (cnt_nxt_i == cmp_eff);
  assign cu_d    = step_up_i && hit;
  assign cd_d    = step_dn_i && hit;

  always_comb begin
    pwm_d = pwm_q;
    if (!run_i)    pwm_d = 1'b0;
    else if (cu_d) pwm_d = 1'b1;
    else if (cd_d) pwm_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      cu_q  <= 1'b0;
      cd_q  <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      if (at_zero_i) cmp_q <= cmp_i;
      cu_q  <= cu_d;
      cd_q  <= cd_d;
      pwm_q <= pwm_d;
    end
  end

  assign cmpu_evt_o = cu_q;
  assign cmpd_evt_o = cd_q;
  assign pwm_o      = pwm_q;
endmodule

// File: rtl/pwm_pair_center.sv
module pwm_pair_center
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CH-1:0]            en_i,
  input  logic                         comp_mode_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] period_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_i,
  output logic [NUM_CH-1:0][CNT_W-1:0] cnt_o,
  output logic [NUM_CH-1:0]            dir_up_o,
  output logic [NUM_CH-1:0]            zero_evt_o,
  output logic [NUM_CH-1:0]            center_evt_o,
  output logic [NUM_CH-1:0]            cmpu_evt_o,
  output logic [NUM_CH-1:0]            cmpd_evt_o,
  output logic [NUM_CH-1:0]            pwm_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_nxt;
  logic [NUM_CH-1:0]            step_up, step_dn, at_zero, pwm_raw;
  pair_mode_e                   mode;

  assign mode = pair_mode_e'(comp_mode_i);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic src_run, src_zero, src_up, src_dn;
    logic [CNT_W-1:0] src_nxt;

    pwm_updown_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en_i[n]),
      .period_i     (period_i[n]),
      .cnt_o        (cnt_o[n]),
      .dir_up_o     (dir_up_o[n]),
      .cnt_nxt_o    (cnt_nxt[n]),
      .step_up_o    (step_up[n]),
      .step_dn_o    (step_dn[n]),
      .at_zero_o    (at_zero[n]),
      .zero_evt_o   (zero_evt_o[n]),
      .center_evt_o (center_evt_o[n])
    );

    if (n % 2 == 0) begin : g_even
      assign src_run  = en_i[n];
      assign src_zero = at_zero[n];
      assign src_up   = step_up[n];
      assign src_dn   = step_dn[n];
      assign src_nxt  = cnt_nxt[n];
    end else begin : g_odd
      // complementary: odd comparator follows the even counter
      logic use_even;
      assign use_even = (mode == MODE_COMPL);
      assign src_run  = use_even ? en_i[n-1]    : en_i[n];
      assign src_zero = use_even ? at_zero[n-1] : at_zero[n];
      assign src_up   = use_even ? step_up[n-1] : step_up[n];
      assign src_dn   = use_even ? step_dn[n-1] : step_dn[n];
      assign src_nxt  = use_even ? cnt_nxt[n-1] : cnt_nxt[n];
    end

    pwm_cmp_chan #(.CNT_W(CNT_W)) i_cmp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (src_run),
      .at_zero_i  (src_zero),
      .step_up_i  (src_up),
      .step_dn_i  (src_dn),
      .cnt_nxt_i  (src_nxt),
      .cmp_i      (cmp_i[n]),
      .cmpu_evt_o (cmpu_evt_o[n]),
      .cmpd_evt_o (cmpd_evt_o[n]),
      .pwm_o      (pwm_raw[n])
    );

    if (n % 2 == 0) begin : g_out_even
      assign pwm_o[n] = pwm_raw[n];
    end else begin : g_out_odd
      assign pwm_o[n] = (mode == MODE_COMPL) ? ~pwm_raw[n-1] : pwm_raw[n];
    end
  end
endmodule

// File: rtl/pwm_pair_center_chk.sv
module pwm_pair_center_chk #(
  parameter int CNT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            en_i,
  input logic [1:0][CNT_W-1:0] cnt_o,
  input logic [1:0]            dir_up_o,
  input logic [1:0]            zero_evt_o,
  input logic [1:0]            center_evt_o,
  input logic [1:0]            cmpu_evt_o,
  input logic [1:0]            cmpd_evt_o,
  input logic [1:0]            pwm_o
);
  for (genvar n = 0; n < 2; n++) begin : g_a
    // R1
    unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_i[n]) |-> (cnt_o[n] == $past(cnt_o[n]) + 1'b1) ||
                         (cnt_o[n] == $past(cnt_o[n]) - 1'b1) ||
                         (cnt_o[n] == '0 && $past(cnt_o[n]) == '0));
    // R2
    dir_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o[n] == '0) |-> dir_up_o[n]);
    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(en_i[n]) |-> (cnt_o[n] == '0) && !zero_evt_o[n] && !center_evt_o[n]);
    // R4
    zero_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_evt_o[n] |-> (cnt_o[n] == '0));
    // R4
    center_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      center_evt_o[n] |-> !dir_up_o[n] && (cnt_o[n] != '0));
    // R4
    zero_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_evt_o[n] |=> !zero_evt_o[n]);
    // R5
    cmp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cmpu_evt_o[n] && cmpd_evt_o[n]));
  end
  // R6
  pwm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o[0]) |-> cmpu_evt_o[0]);
  // R6
  pwm_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_o[0]) |-> cmpd_evt_o[0] || !$past(en_i[0]));
endmodule

bind pwm_pair_center pwm_pair_center_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .cnt_o        (cnt_o),
  .dir_up_o     (dir_up_o),
  .zero_evt_o   (zero_evt_o),
  .center_evt_o (center_evt_o),
  .cmpu_evt_o   (cmpu_evt_o),
  .cmpd_evt_o   (cmpd_evt_o),
  .pwm_o        (pwm_o)
);

// File: tb/test_pwm_pair_center.sv
module test_pwm_pair_center;
  localparam int W = 16;
  localparam int NV = 6;
  // {mode, p0, p1, c0, c1}
  localparam int VEC [NV][5] = '{
    '{0, 4, 4, 2, 1},
    '{0, 5, 3, 1, 2},
    '{0, 6, 2, 0, 2},
    '{1, 5, 3, 2, 4},
    '{1, 3, 7, 1, 1},
    '{0, 3, 3, 7, 3}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] en = '0;
  logic comp = 0;
  logic [1:0][W-1:0] per = '0, cmp = '0;
  logic [1:0][W-1:0] cnt;
  logic [1:0] dir, zev, cev, cuev, cdev, pwm;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_pair_center #(.CNT_W(W)) i_pwm_pair_center (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .comp_mode_i(comp),
    .period_i(per), .cmp_i(cmp), .cnt_o(cnt), .dir_up_o(dir),
    .zero_evt_o(zev), .center_evt_o(cev), .cmpu_evt_o(cuev),
    .cmpd_evt_o(cdev), .pwm_o(pwm)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tri_cnt(int i, int p);
    int m = i % (2 * p);
    return (m <= p) ? m : 2 * p - m;
  endfunction

  function automatic int exp_cu(int c, int p, int k);
    return (c >= 1 && c <= p) ? k : 0;
  endfunction

  function automatic int exp_cd(int c, int p, int k);
    return (c >= 0 && c < p) ? k : 0;
  endfunction

  function automatic int exp_hi(int c, int p, int w);
    if (c >= 1 && c < p) return (w / (2 * p)) * 2 * (p - c);
    if (c == p) return w - p + 1;
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cnt", int'(cnt), 0);
    chk("R10 dir", int'(dir), 3);
    chk("R10 events", int'({zev, cev, cuev, cdev}), 0);
    chk("R10 pwm", int'(pwm), 0);

    // R1 R2 R4 ramp with P=4
    per[0] = 4; cmp[0] = 2;
    en[0] = 1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      chk("R1 ramp", int'(cnt[0]), tri_cnt(i, 4));
      chk("R2 dir", int'(dir[0]), ((i % 8) < 4) ? 1 : 0);
      chk("R4 center", int'(cev[0]), (i % 8 == 4) ? 1 : 0);
      chk("R4 zero", int'(zev[0]), (i % 8 == 0) ? 1 : 0);
    end
    // now cnt=2 rising (i=10); R9 change mid-period
    per[0] = 6;
    @(negedge clk); chk("R9 old period", int'(cnt[0]), 3);
    @(negedge clk); chk("R9 old turn", int'(cnt[0]), 4);
    chk("R9 old turn dir", int'(dir[0]), 0);
    repeat (4) @(negedge clk);
    chk("R9 zero", int'(cnt[0]), 0);
    repeat (6) @(negedge clk);
    chk("R9 new turn", int'(cnt[0]), 6);
    chk("R9 new center", int'(cev[0]), 1);

    // R3 disable mid-period
    @(negedge clk);
    en[0] = 0;
    @(negedge clk);
    chk("R3 cleared", int'(cnt[0]), 0);
    chk("R3 dir", int'(dir[0]), 1);
    chk("R3 pwm", int'(pwm[0]), 0);
    begin
      int ev = 0;
      repeat (4) begin
        @(negedge clk);
        ev += int'(zev[0]) + int'(cev[0]) + int'(cnt[0] != 0);
      end
      chk("R3 idle quiet", ev, 0);
    end
    en[0] = 1; per[0] = 3;
    @(negedge clk);
    chk("R3 restart", int'(cnt[0]), 1);
    en[0] = 0;
    @(negedge clk);

    // R1 period zero holds
    per[0] = 0; en[0] = 1;
    begin
      int ev = 0;
      repeat (5) begin
        @(negedge clk);
        ev += int'(cnt[0] != 0) + int'(zev[0]) + int'(cev[0]);
      end
      chk("R1 zero period holds", ev, 0);
    end
    en[0] = 0;
    @(negedge clk);

    // Sweep table: R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int p0 = VEC[v][1], p1 = VEC[v][2], c0 = VEC[v][3], c1 = VEC[v][4];
      int w = 2 * p0 * p1;
      int nz[2], nc[2], nu[2], nd[2], nh[2];
      int k0 = w / (2 * p0), k1 = w / (2 * p1);
      int pc1 = VEC[v][0] ? p0 : p1;
      int kc1 = VEC[v][0] ? k0 : k1;
      int eh1;
      comp = VEC[v][0][0];
      per[0] = p0; per[1] = p1; cmp[0] = c0; cmp[1] = c1;
      @(negedge clk);
      en = 2'b11;
      for (int ch = 0; ch < 2; ch++) begin
        nz[ch] = 0; nc[ch] = 0; nu[ch] = 0; nd[ch] = 0; nh[ch] = 0;
      end
      for (int i = 1; i <= w; i++) begin
        @(negedge clk);
        for (int ch = 0; ch < 2; ch++) begin
          nz[ch] += int'(zev[ch]); nc[ch] += int'(cev[ch]);
          nu[ch] += int'(cuev[ch]); nd[ch] += int'(cdev[ch]);
          nh[ch] += int'(pwm[ch]);
        end
      end
      eh1 = VEC[v][0] ? (w - exp_hi(c0, p0, w)) : exp_hi(c1, p1, w);
      chk("R4 zero count ch0", nz[0], k0);
      chk("R4 center count ch0", nc[0], k0);
      chk("R5 cmpu ch0", nu[0], exp_cu(c0, p0, k0));
      chk("R5 cmpd ch0", nd[0], exp_cd(c0, p0, k0));
      chk("R6 high ch0", nh[0], exp_hi(c0, p0, w));
      chk("R8 R7 odd counter zero", nz[1], k1);
      chk("R8 R7 odd counter center", nc[1], k1);
      chk(VEC[v][0] ? "R8 cmpu ch1" : "R7 cmpu ch1", nu[1], exp_cu(c1, pc1, kc1));
      chk(VEC[v][0] ? "R8 cmpd ch1" : "R7 cmpd ch1", nd[1], exp_cd(c1, pc1, kc1));
      chk(VEC[v][0] ? "R8 inverse ch1" : "R7 high ch1", nh[1], eh1);
      en = 2'b00;
      repeat (2) @(negedge clk);
    end

    comp = 0;
    @(negedge clk);
    chk("R3 final idle pwm", int'(pwm), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule